// File: doc/BRIEF.md
# Three-Channel Phase-Programmable PWM

This block drives three pulse-width-modulated lines from one shared period counter. The counter advances once per tick of a selected time base, counts from zero up to a programmed period limit and then wraps. Each line has its own rising-edge position and falling-edge position on that common count. Lines can therefore carry pulses of different widths and phase offsets that stay locked to one period. Register decoding and clock generation sit outside the block. The fast and slow time bases arrive as single-cycle tick enables in the block's own clock domain.

Edge positions and the period limit take effect only at a period boundary, or at any time while the block is disabled. A rewrite in the middle of a period therefore never produces a truncated or doubled pulse. Two override rules cover edge values that fall outside the period. A rising edge beyond the limit, or equal rising and falling edges, keeps the line low. A falling edge beyond the limit, with an in-range rising edge, keeps the line high. Counting can be frozen by a software pause, or by an external pause input when that input has been armed.

Top module: `tpwm_triple`

## Requirements
- R1: After reset, and one clock after `enable` is low at an edge, all three `pwm_out` bits are 0 and the shared count is 0.
- R2: With `enable` high and ticks arriving on every cycle, the count runs 0, 1, ..., `period_max`, 0, ... The period is therefore `period_max`+1 ticks. `pwm_out` shows the level for count value k one clock after the edge at which the count held k.
- R3: When start <= end <= `period_max` and start != end, a line is 1 exactly while start <= count < end.
- R4: When end < start <= `period_max`, a line is 1 while count >= start or count < end, so the pulse wraps across the period boundary.
- R5: When start > `period_max`, or end equals start, the line stays 0 for the whole period.
- R6: When end > `period_max` and start <= `period_max` (and start != end), the line stays 1 for the whole period.
- R7: `tick_sel` = 1 advances the count on `fast_tick` and ignores `slow_tick`. `tick_sel` = 0 advances on `slow_tick` and ignores `fast_tick`.
- R8: While `sw_pause` is 1 the count does not advance and every line holds its level.
- R9: While `hw_pause_arm` and `hw_pause` are both 1 the count and lines freeze. With `hw_pause_arm` at 0, `hw_pause` has no effect.
- R10: New start, end and `period_max` values are taken only at the edge where the count wraps, or while disabled. A period in progress finishes with the values it began with.
- R11: Each channel i uses only its own field `start_cyc[i*14 +: 14]` and `end_cyc[i*14 +: 14]`. The other lines are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the counter; 0 holds count and outputs at 0 |
| tick_sel | input | 1 | Time base select: 1 fast tick, 0 slow tick |
| fast_tick | input | 1 | Single-cycle enable from the fast time base |
| slow_tick | input | 1 | Single-cycle enable from the slow time base |
| sw_pause | input | 1 | Software freeze of the counter |
| hw_pause_arm | input | 1 | Allows `hw_pause` to freeze the counter |
| hw_pause | input | 1 | External freeze request |
| period_max | input | 14 | Last count value of the period |
| start_cyc | input | 42 | Rising-edge count per channel, 14 bits each, channel 0 in the low bits |
| end_cyc | input | 42 | Falling-edge count per channel, 14 bits each, channel 0 in the low bits |
| pwm_out | output | 3 | PWM lines, bit i for channel i |

## Verification
The assertions assume that `period_max`, `start_cyc` and `end_cyc` hold steady around each edge. They also assume the tick inputs are synchronous single-cycle enables. They make no assumption about when the configuration changes relative to the count, since the block shadows it. The stimulus changes inputs only on the falling clock edge. It rewrites edge values in the middle of a period on purpose, to show that the shadow copies absorb the change. Pause, arm and tick-select inputs are toggled while the counter is running, and every window assertion is gated by `enable` so that disable phases stay legal.

// File: rtl/tpwm_pkg.sv
// Package: shared constants and window classification for the triple PWM.
// Assumes: nothing beyond IEEE 1800-2017.
package tpwm_pkg;

    localparam int unsigned TPWM_CNT_W = 14;
    localparam int unsigned TPWM_NUM_CH = 3;

    // How one channel's edge pair maps onto the period.
    typedef enum logic [1:0] {
        WIN_LOW    = 2'd0,  // line held at 0
        WIN_HIGH   = 2'd1,  // line held at 1
        WIN_INSIDE = 2'd2,  // high for start <= count < end
        WIN_WRAP   = 2'd3   // high for count >= start or count < end
    } win_kind_t;

endpackage

// File: rtl/tpwm_tick_gate.sv
// Module: tpwm_tick_gate
// Picks the active time base and folds in enable and both pause sources
// into one advance strobe for the period counter.
// Assumes: tick inputs are synchronous single-cycle enables.
module tpwm_tick_gate (
    input  logic enable,
    input  logic tick_sel,
    input  logic fast_tick,
    input  logic slow_tick,
    input  logic sw_pause,
    input  logic hw_pause_arm,
    input  logic hw_pause,
    output logic advance
);

    logic tick_raw;
    logic frozen;

    // Select fast or slow tick.
    always_comb tick_raw = tick_sel ? fast_tick : slow_tick;

    // Combine both pause sources.
    always_comb frozen = sw_pause | (hw_pause_arm & hw_pause);

    // Advance only when running, ticking and not frozen.
    always_comb advance = enable & tick_raw & ~frozen;

endmodule

// File: rtl/tpwm_period_ctr.sv
// Module: tpwm_period_ctr
// Shared period counter: runs 0..limit and wraps. It keeps a shadow copy of
// the limit and raises a load strobe whenever new configuration may be taken.
// Assumes: advance is low when enable is low.
module tpwm_period_ctr #(
    parameter int unsigned CNT_W = tpwm_pkg::TPWM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             advance,
    input  logic [CNT_W-1:0] limit_in,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit_sh,
    output logic             load
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] limit_q;
    logic             at_wrap;

    // Detect the last count of the period.
    always_comb at_wrap = (count_q >= limit_q);

    // Configuration may be taken while idle or at the wrap edge.
    always_comb load = ~enable | (advance & at_wrap);

    // Step, wrap or clear the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!enable) begin
            count_q <= '0;
        end else if (advance) begin
            count_q <= at_wrap ? '0 : count_q + CNT_W'(1);
        end
    end

    // Shadow the period limit at load points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (load) begin
            limit_q <= limit_in;
        end
    end

    assign count    = count_q;
    assign limit_sh = limit_q;

    // R2: the count never leaves 0..limit
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= limit_q);

    // R2: a tick below the limit steps the count by exactly one
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && advance && (count_q < limit_q)) |=> (count_q == CNT_W'($past(count_q) + 1)));

    // R1: disabling clears the count on the next edge
    a_r1_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (count_q == '0));

endmodule

// File: rtl/tpwm_channel.sv
// Module: tpwm_channel
// One PWM line: shadows its edge pair at load points, classifies the window
// against the shadowed limit and registers the resulting level.
// Assumes: count is in 0..limit_sh; load comes from the shared counter.
module tpwm_channel #(
    parameter int unsigned CNT_W = tpwm_pkg::TPWM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] limit_sh,
    input  logic [CNT_W-1:0] rise_in,
    input  logic [CNT_W-1:0] fall_in,
    output logic             level
);

    import tpwm_pkg::*;

    logic [CNT_W-1:0] rise_q;
    logic [CNT_W-1:0] fall_q;
    win_kind_t        kind;
    logic             level_d;
    logic             level_q;

    // Take the edge pair only at load points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else if (load) begin
            rise_q <= rise_in;
            fall_q <= fall_in;
        end
    end

    // Classify the edge pair with the override rules first.
    always_comb begin
        if ((rise_q > limit_sh) || (rise_q == fall_q)) begin
            kind = WIN_LOW;
        end else if (fall_q > limit_sh) begin
            kind = WIN_HIGH;
        end else if (rise_q < fall_q) begin
            kind = WIN_INSIDE;
        end else begin
            kind = WIN_WRAP;
        end
    end

    // Evaluate the line level for the current count.
    always_comb begin
        unique case (kind)
            WIN_LOW:    level_d = 1'b0;
            WIN_HIGH:   level_d = 1'b1;
            WIN_INSIDE: level_d = (count >= rise_q) && (count < fall_q);
            WIN_WRAP:   level_d = (count >= rise_q) || (count < fall_q);
            default:    level_d = 1'b0;
        endcase
    end

    // Register the line; idle forces it low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else if (!enable) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_d;
        end
    end

    assign level = level_q;

    // R1: an idle edge leaves the line low
    a_r1_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !level_q);

    // R5: out-of-range or empty window keeps the line low
    a_r5_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ((rise_q > limit_sh) || (rise_q == fall_q))) |=> !level_q);

    // R6: falling edge past the limit keeps the line high
    a_r6_forced_high: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (rise_q <= limit_sh) && (fall_q > limit_sh) && (rise_q != fall_q)) |=> level_q);

    // R10: shadow edges change only while the count sits at zero
    a_r10_shadow_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rise_q) || !$stable(fall_q)) |-> (count == '0));

endmodule

// File: rtl/tpwm_triple.sv
// Module: tpwm_triple
// Top of the three-channel PWM: one tick gate, one shared period counter
// and a generated row of channels.
// Assumes: all inputs are synchronous to clk; config fields are 14 bits each.
module tpwm_triple #(
    parameter int unsigned CNT_W  = tpwm_pkg::TPWM_CNT_W,
    parameter int unsigned NUM_CH = tpwm_pkg::TPWM_NUM_CH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    tick_sel,
    input  logic                    fast_tick,
    input  logic                    slow_tick,
    input  logic                    sw_pause,
    input  logic                    hw_pause_arm,
    input  logic                    hw_pause,
    input  logic [CNT_W-1:0]        period_max,
    input  logic [NUM_CH*CNT_W-1:0] start_cyc,
    input  logic [NUM_CH*CNT_W-1:0] end_cyc,
    output logic [NUM_CH-1:0]       pwm_out
);

    logic             advance;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] limit_sh;
    logic             load;

    tpwm_tick_gate u_gate (
        .enable      (enable),
        .tick_sel    (tick_sel),
        .fast_tick   (fast_tick),
        .slow_tick   (slow_tick),
        .sw_pause    (sw_pause),
        .hw_pause_arm(hw_pause_arm),
        .hw_pause    (hw_pause),
        .advance     (advance)
    );

    tpwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .advance (advance),
        .limit_in(period_max),
        .count   (count),
        .limit_sh(limit_sh),
        .load    (load)
    );

    // R11: one channel per output bit, each on its own config slice
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        tpwm_channel #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (enable),
            .load    (load),
            .count   (count),
            .limit_sh(limit_sh),
            .rise_in (start_cyc[ch*CNT_W +: CNT_W]),
            .fall_in (end_cyc[ch*CNT_W +: CNT_W]),
            .level   (pwm_out[ch])
        );
    end

    // R7: with the slow base selected and no slow tick, the count holds
    a_r7_slow_base_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick_sel && !slow_tick) |=> $stable(count));

    // R8: software pause holds the count
    a_r8_sw_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sw_pause) |=> $stable(count));

    // R9: armed external pause holds the count
    a_r9_hw_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && hw_pause_arm && hw_pause) |=> $stable(count));

    // R8: a held count keeps every line steady
    a_r8_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !advance && !$past(advance)) |=> $stable(pwm_out));

endmodule

// File: tb/tpwm_triple_tb.sv
module tpwm_triple_tb;

    localparam int W  = 14;
    localparam int NC = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable = 1'b0;
    logic            tick_sel = 1'b1;
    logic            fast_tick = 1'b1;
    logic            slow_tick = 1'b0;
    logic            sw_pause = 1'b0;
    logic            hw_pause_arm = 1'b1;
    logic            hw_pause = 1'b0;
    logic [W-1:0]    period_max = '0;
    logic [NC*W-1:0] start_cyc = '0;
    logic [NC*W-1:0] end_cyc = '0;
    logic [NC-1:0]   pwm_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    tpwm_triple u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick_sel(tick_sel),
        .fast_tick(fast_tick), .slow_tick(slow_tick), .sw_pause(sw_pause),
        .hw_pause_arm(hw_pause_arm), .hw_pause(hw_pause),
        .period_max(period_max), .start_cyc(start_cyc), .end_cyc(end_cyc),
        .pwm_out(pwm_out)
    );

    // Vector: {limit, start, end, high count per period, first high index (63 = none)}
    localparam int NV = 8;
    localparam logic [57:0] VEC [NV] = '{
        {14'd9, 14'd2,  14'd5,  8'd3,  8'd2},   // R3 plain window
        {14'd9, 14'd7,  14'd2,  8'd5,  8'd0},   // R4 wrapped window
        {14'd9, 14'd10, 14'd3,  8'd0,  8'd63},  // R5 start past limit
        {14'd9, 14'd4,  14'd4,  8'd0,  8'd63},  // R5 start equals end
        {14'd9, 14'd3,  14'd12, 8'd10, 8'd0},   // R6 end past limit
        {14'd0, 14'd0,  14'd1,  8'd1,  8'd0},   // R6 one-tick period
        {14'd5, 14'd0,  14'd5,  8'd5,  8'd0},   // R2 R3 short period
        {14'd9, 14'd9,  14'd0,  8'd1,  8'd9}    // R4 wrap at last count
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic set_cfg(input int ch, input int lim, input int s, input int e);
        period_max = W'(lim);
        start_cyc = '0;
        end_cyc = '0;
        start_cyc[ch*W +: W] = W'(s);
        end_cyc[ch*W +: W] = W'(e);
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        // R1: reset state, still disabled
        check(pwm_out == 3'b000, "R1 reset", int'(pwm_out), 0);

        // Table walk: each vector on channel (index mod 3), others left empty.
        for (int v = 0; v < NV; v++) begin
            int lim, s, e, duty, first, ch, per, hits, seen, other;
            {lim, s, e, duty, first} = {18'd0, VEC[v][57:44], 18'd0, VEC[v][43:30],
                                        18'd0, VEC[v][29:16], 24'd0, VEC[v][15:8],
                                        24'd0, VEC[v][7:0]};
            ch = v % NC;
            per = lim + 1;
            enable = 1'b0;
            set_cfg(ch, lim, s, e);
            cycles(2);
            enable = 1'b1;
            hits = 0;
            seen = 63;
            other = 0;
            for (int i = 0; i < 2 * per; i++) begin
                @(negedge clk);
                if (pwm_out[ch]) begin
                    hits++;
                    if (seen == 63) seen = i;
                end
                if ((pwm_out & ~(3'b001 << ch)) != 0) other++;
            end
            check(hits == 2 * duty, "R2/R3-R6 duty", hits, 2 * duty);
            check(seen == first, "R3/R4 first high", seen, first);
            check(other == 0, "R11 other lines", other, 0);
        end

        // R1: disable forces outputs low one clock later
        enable = 1'b0;
        set_cfg(0, 9, 0, 12);
        cycles(2);
        enable = 1'b1;
        cycles(3);
        check(pwm_out[0] == 1'b1, "R6 before disable", int'(pwm_out[0]), 1);
        enable = 1'b0;
        cycles(1);
        check(pwm_out == 3'b000, "R1 disable", int'(pwm_out), 0);

        // R10: mid-period rewrite waits for the wrap
        set_cfg(1, 9, 2, 5);
        cycles(2);
        enable = 1'b1;
        cycles(6);   // samples i = 0..5 done
        start_cyc[1*W +: W] = W'(6);
        end_cyc[1*W +: W] = W'(8);
        begin
            int early;
            early = 0;
            for (int i = 6; i < 10; i++) begin
                @(negedge clk);
                if (pwm_out[1]) early++;
            end
            check(early == 0, "R10 old values kept", early, 0);
            cycles(2);   // i = 10, 11
            cycles(1);   // i = 12
            check(pwm_out[1] == 1'b0, "R10 new window low at 2", int'(pwm_out[1]), 0);
            cycles(4);   // i = 16
            check(pwm_out[1] == 1'b1, "R10 new window high at 6", int'(pwm_out[1]), 1);
        end

        // R8 / R9: freezes while high
        enable = 1'b0;
        set_cfg(0, 9, 0, 5);
        cycles(2);
        enable = 1'b1;
        cycles(3);
        sw_pause = 1'b1;
        begin
            int lows;
            lows = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (!pwm_out[0]) lows++;
            end
            check(lows == 0, "R8 sw pause holds", lows, 0);
            sw_pause = 1'b0;
            hw_pause_arm = 1'b1;
            hw_pause = 1'b1;
            lows = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (!pwm_out[0]) lows++;
            end
            check(lows == 0, "R9 armed hw pause holds", lows, 0);
            hw_pause_arm = 1'b0;
            lows = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (!pwm_out[0]) lows++;
            end
            check(lows > 0, "R9 unarmed hw pause ignored", lows, 1);
            hw_pause = 1'b0;
            hw_pause_arm = 1'b1;
        end

        // R7: slow base selected, fast ticks must not count
        enable = 1'b0;
        set_cfg(2, 9, 0, 1);
        tick_sel = 1'b0;
        slow_tick = 1'b0;
        cycles(2);
        enable = 1'b1;
        begin
            int lows;
            lows = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (!pwm_out[2]) lows++;
            end
            check(lows == 0, "R7 fast tick ignored", lows, 0);
        end
        slow_tick = 1'b1;
        cycles(3);
        check(pwm_out[2] == 1'b0, "R7 slow tick counts", int'(pwm_out[2]), 0);
        slow_tick = 1'b0;
        tick_sel = 1'b1;
        enable = 1'b0;
        cycles(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule